// File: doc/BRIEF.md
# Five-Channel 16-Bit Compare Timer Bank

This block holds several independent up-counting timer channels, five by default. Each channel picks its count source from two groups. The first group is the system clock divided by 1, 2, 4 or 8, taken from one shared prescaler. The second group is one of four external clock pins, counted on the rising edge, the falling edge or both edges. A channel counts only while its bit in a shared run register is 1.

Each channel holds two compare registers, A and B. It can run free, wrapping from the all-ones value to zero, or it can run as a periodic counter that is cleared by a match on A or on B. Overflow, match-A and match-B events each set a sticky status flag. Every flag has its own enable, and each channel drives a level interrupt.

Software reaches all state through a synchronous register port. A write takes effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after the address is presented.

Top module: `ctimer_bank`

## Requirements
- R1: After reset every counter is 0x0000, the run register is 0, every control register is 0 (prescale /1, rising edge, no compare clearing), all flags and enables are 0, both compare registers read 0xFFFF, and all interrupt outputs are low.
- R2: A channel's counter changes only on a count tick while its own bit of the run register (address 0, bit n for channel n) is 1, or when software writes it; the counters of other channels are unaffected.
- R3: On a tick with the counter at 0xFFFF and no compare clear, the counter becomes 0x0000 and the overflow flag (status bit 0) is set; counting then continues from zero.
- R4: Interrupt output n equals the OR of the status flags of channel n that are set and enabled (enable register bits 0 overflow, 1 match A, 2 match B); it stays high until those flags are cleared or disabled.
- R5: Control bits [6:5] choose the clear source: 00 or 11 none, 01 match on A, 10 match on B. On a tick where the counter equals the selected compare register, the counter goes to 0x0000, so the period is compare value + 1 ticks.
- R6: On any tick where the counter equals register A, status bit 1 is set, and where it equals register B, status bit 2 is set, whether or not that register is the clear source; only the selected register clears the counter.
- R7: Writing the status register clears each flag whose written bit is 0 and leaves flags whose written bit is 1; if an event for a flag occurs in the same cycle as its clear, the flag ends up set.
- R8: Control bits [2:0] values 0, 1, 2, 3 count the system clock divided by 1, 2, 4 and 8; over any window of 32 consecutive cycles, a running channel advances 32, 16, 8 and 4 times respectively.
- R9: Control bits [2:0] values 4 to 7 count external pin 0 to 3 through a two-flop synchronizer. Bits [4:3] choose the edge: 00 rising, 01 falling, 10 or 11 both.
- R10: Within channel n, at slot address (n+1)*8, offsets are 0 control, 1 enable, 2 status, 3 counter, 4 compare A, and 5 compare B. A read returns the addressed register one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Register address: slot in upper bits, register offset in bits [2:0] |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data, registered, for the address of the previous cycle |
| ext_clk | input | 4 | Asynchronous external count clocks |
| irq | output | NUM_CH (5) | Level interrupt request per channel |

## Verification
The bench builds the block with its defaults: five channels, 16-bit counters and a 6-bit address. This covers the full wrap at 0xFFFF, the highest channel slot and all four prescaler ratios. A 32-cycle run window is a multiple of every divide ratio, so expected counts do not depend on the prescaler phase. Periodic clearing uses small compare values that wrap several times inside one window. The cycle where a status clear meets a match is reached by placing the clear write a fixed number of ticks after the start write.

// File: rtl/ctimer_pkg.sv
// Shared constants and types for the compare timer bank.
// Assumes a 3-bit register offset inside each channel slot.
package ctimer_pkg;

    localparam int OFS_W     = 3;
    localparam int EXT_PINS  = 4;
    localparam int DIV_CHOICES = 4;
    localparam int FLAG_W    = 3;

    localparam logic [OFS_W-1:0] REG_CTRL = 3'd0;
    localparam logic [OFS_W-1:0] REG_IEN  = 3'd1;
    localparam logic [OFS_W-1:0] REG_STAT = 3'd2;
    localparam logic [OFS_W-1:0] REG_CNT  = 3'd3;
    localparam logic [OFS_W-1:0] REG_CMPA = 3'd4;
    localparam logic [OFS_W-1:0] REG_CMPB = 3'd5;

    localparam int FLG_OVF = 0;
    localparam int FLG_A   = 1;
    localparam int FLG_B   = 2;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_OFF  = 2'b11
    } clr_sel_e;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_BOTH  = 2'b10,
        EDGE_BOTHX = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/ctimer_prescale.sv
// Free-running prescaler producing one-cycle ticks at clk/1, /2, /4, /8 ...
// Assumes ticks are consumed in the same clock domain; tick[0] is always high.
module ctimer_prescale #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES:0]   tick
);

    logic [STAGES-1:0] pre_q;

    // Advance the divider chain every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    assign tick[0] = 1'b1;

    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_tick
            assign tick[i] = &pre_q[i-1:0];
        end
    endgenerate

endmodule

// File: rtl/ctimer_edge_sync.sv
// Two-flop synchronizer for one asynchronous pin plus edge detection.
// Assumes the pin stays at each level for at least two clock cycles.
module ctimer_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic s1_q, s2_q, s3_q;

    // Synchronize the pin and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;

endmodule

// File: rtl/ctimer_channel.sv
// One timer channel: source select, counter, two compare registers,
// sticky flags with enables and a level interrupt.
// Assumes writes come one per cycle from the bank decoder.
module ctimer_channel
    import ctimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [DIV_CHOICES-1:0]  div_tick,
    input  logic [EXT_PINS-1:0]     ext_rise,
    input  logic [EXT_PINS-1:0]     ext_fall,
    input  logic                    wr_en,
    input  logic [OFS_W-1:0]        reg_sel,
    input  logic [CNT_W-1:0]        wdata,
    output logic [CNT_W-1:0]        rd_val,
    output logic                    irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0]         src_q;
    edge_sel_e          edge_q;
    clr_sel_e           clr_q;
    logic [FLAG_W-1:0]  ien_q;
    logic [FLAG_W-1:0]  stat_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cmpa_q;
    logic [CNT_W-1:0]   cmpb_q;

    logic               tick;
    logic               advance;
    logic               hit_a, hit_b;
    logic               clear_now;
    logic [FLAG_W-1:0]  events;
    logic               wr_cnt;

    // Pick the count tick from the prescaler or an external pin edge.
    always_comb begin
        if (!src_q[2]) begin
            tick = div_tick[src_q[1:0]];
        end else begin
            unique case (edge_q)
                EDGE_RISE: tick = ext_rise[src_q[1:0]];
                EDGE_FALL: tick = ext_fall[src_q[1:0]];
                default:   tick = ext_rise[src_q[1:0]] | ext_fall[src_q[1:0]];
            endcase
        end
    end

    assign advance   = run & tick;
    assign hit_a     = (cnt_q == cmpa_q);
    assign hit_b     = (cnt_q == cmpb_q);
    assign clear_now = advance & (((clr_q == CLR_ON_A) & hit_a) |
                                  ((clr_q == CLR_ON_B) & hit_b));
    assign wr_cnt    = wr_en & (reg_sel == REG_CNT);

    // Collect the events seen on this tick.
    always_comb begin
        events          = '0;
        events[FLG_OVF] = advance & (cnt_q == CNT_MAX) & ~clear_now;
        events[FLG_A]   = advance & hit_a;
        events[FLG_B]   = advance & hit_b;
    end

    // Control, enable and compare registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            edge_q <= EDGE_RISE;
            clr_q  <= CLR_NONE;
            ien_q  <= '0;
            cmpa_q <= '1;
            cmpb_q <= '1;
        end else if (wr_en) begin
            case (reg_sel)
                REG_CTRL: begin
                    src_q  <= wdata[2:0];
                    edge_q <= edge_sel_e'(wdata[4:3]);
                    clr_q  <= clr_sel_e'(wdata[6:5]);
                end
                REG_IEN:  ien_q  <= wdata[FLAG_W-1:0];
                REG_CMPA: cmpa_q <= wdata;
                REG_CMPB: cmpb_q <= wdata;
                default: ;
            endcase
        end
    end

    // Counter: software write first, then compare clear, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (wr_cnt)    cnt_q <= wdata;
        else if (clear_now) cnt_q <= '0;
        else if (advance)   cnt_q <= cnt_q + 1'b1;
    end

    // Sticky flags: write-0 clears, a same-cycle event keeps the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else if (wr_en && reg_sel == REG_STAT)
            stat_q <= (stat_q & wdata[FLAG_W-1:0]) | events;
        else
            stat_q <= stat_q | events;
    end

    // Register readback for the bank's read mux.
    always_comb begin
        rd_val = '0;
        case (reg_sel)
            REG_CTRL: rd_val[6:0] = {clr_q, edge_q, src_q};
            REG_IEN:  rd_val[FLAG_W-1:0] = ien_q;
            REG_STAT: rd_val[FLAG_W-1:0] = stat_q;
            REG_CNT:  rd_val = cnt_q;
            REG_CMPA: rd_val = cmpa_q;
            REG_CMPB: rd_val = cmpb_q;
            default:  rd_val = '0;
        endcase
    end

    assign irq = |(stat_q & ien_q);

    // R2: a stopped channel's counter holds unless software writes it.
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> (cnt_q == $past(cnt_q)));

    // R3: a tick at all-ones with no compare clear wraps and flags overflow.
    p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cnt_q == CNT_MAX && !wr_cnt &&
         !(clr_q == CLR_ON_A && hit_a) && !(clr_q == CLR_ON_B && hit_b))
        |=> (cnt_q == '0 && stat_q[FLG_OVF]));

    // R5: a tick on the selected A match returns the counter to zero.
    p_clear_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && clr_q == CLR_ON_A && hit_a && !wr_cnt) |=> (cnt_q == '0));

    // R6: a B match sets its flag even when A is the clear source.
    p_flag_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && hit_b) |=> stat_q[FLG_B]);

endmodule

// File: rtl/ctimer_bank.sv
// Bank of compare timer channels with shared prescaler, external clock
// synchronizers, run register and a registered-read register port.
// Assumes NUM_CH <= CNT_W and NUM_CH + 1 slots fit in ADDR_W - 3 bits.
module ctimer_bank
    import ctimer_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic [EXT_PINS-1:0]  ext_clk,
    output logic [NUM_CH-1:0]    irq
);

    localparam int SLOT_W = ADDR_W - OFS_W;
    localparam int STAGES = DIV_CHOICES - 1;

    logic [SLOT_W-1:0]      slot;
    logic [OFS_W-1:0]       ofs;
    logic [NUM_CH-1:0]      run_q;
    logic [DIV_CHOICES-1:0] div_tick;
    logic [EXT_PINS-1:0]    ext_rise, ext_fall;
    logic [CNT_W-1:0]       ch_rd [NUM_CH];
    logic [CNT_W-1:0]       rd_next;

    assign slot = bus_addr[ADDR_W-1:OFS_W];
    assign ofs  = bus_addr[OFS_W-1:0];

    ctimer_prescale #(.STAGES(STAGES)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (div_tick)
    );

    generate
        for (genvar p = 0; p < EXT_PINS; p++) begin : g_pin
            ctimer_edge_sync u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (ext_clk[p]),
                .rise  (ext_rise[p]),
                .fall  (ext_fall[p])
            );
        end

        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(c + 1);
            ctimer_channel #(.CNT_W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (run_q[c]),
                .div_tick (div_tick),
                .ext_rise (ext_rise),
                .ext_fall (ext_fall),
                .wr_en    (bus_wr && slot == MY_SLOT),
                .reg_sel  (ofs),
                .wdata    (bus_wdata),
                .rd_val   (ch_rd[c]),
                .irq      (irq[c])
            );

            // R4: with no write, nothing can clear flags or enables.
            p_irq_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[c] && !bus_wr) |=> irq[c]);
        end
    endgenerate

    // Shared run register at slot 0, offset 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (bus_wr && slot == '0 && ofs == '0)
            run_q <= bus_wdata[NUM_CH-1:0];
    end

    // Select the addressed register for the read port.
    always_comb begin
        rd_next = '0;
        if (slot == '0 && ofs == '0)
            rd_next[NUM_CH-1:0] = run_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (slot == SLOT_W'(c + 1))
                rd_next = ch_rd[c];
        end
    end

    // Register the read data one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    // R1: interrupts are low in the cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        (!rst_n) |=> (irq == '0 && bus_rdata == '0));

endmodule

// File: tb/ctimer_bank_test.sv
// Directed bench for the compare timer bank.
module ctimer_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  ext_clk = '0;
    logic [4:0]  irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    ctimer_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_clk   (ext_clk),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    function automatic logic [5:0] ra(input int ch, input int ofs);
        return 6'(((ch + 1) << 3) | ofs);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    // Start channel mask, let 32 edges count, then stop everything.
    task automatic run_window(input logic [4:0] mask);
        wr(6'd0, {11'd0, mask});
        repeat (30) @(negedge clk);
        wr(6'd0, 16'd0);
    endtask

    task automatic prep(input int ch, input logic [15:0] ctrl);
        wr(ra(ch, 0), ctrl);
        wr(ra(ch, 3), 16'd0);
        wr(ra(ch, 2), 16'd0);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(6'd0, v);        check("R1 run reg", v, 16'h0000);
        rd(ra(0, 0), v);    check("R1 ctrl", v, 16'h0000);
        rd(ra(4, 3), v);    check("R1 count", v, 16'h0000);
        rd(ra(2, 4), v);    check("R1 cmpA", v, 16'hFFFF);
        rd(ra(3, 2), v);    check("R1 status", v, 16'h0000);
        check("R1 irq", {11'd0, irq}, 16'h0000);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(ra(1, 5), 16'hA55A);
        rd(ra(1, 5), v);    check("R10 cmpB readback", v, 16'hA55A);
        wr(ra(1, 0), 16'h0075);
        rd(ra(1, 0), v);    check("R10 ctrl readback", v, 16'h0075);
        wr(ra(1, 0), 16'h0000);
    endtask

    task automatic t_run_gate;
        logic [15:0] v, w;
        prep(0, 16'h0000);
        prep(4, 16'h0000);
        run_window(5'b00001);
        rd(ra(0, 3), v);    check("R2 ch0 counted", v, 16'd32);
        rd(ra(4, 3), v);    check("R2 ch4 idle", v, 16'd0);
        repeat (10) @(negedge clk);
        rd(ra(0, 3), w);    check("R2 stopped holds", w, 16'd32);
    endtask

    task automatic t_divide;
        logic [15:0] v;
        for (int s = 1; s < 4; s++) begin
            prep(2, 16'(s));
            run_window(5'b00100);
            rd(ra(2, 3), v);
            check($sformatf("R8 divide select %0d", s), v, 16'(32 >> s));
        end
    endtask

    task automatic t_periodic;
        logic [15:0] v;
        wr(ra(0, 4), 16'd4);
        wr(ra(0, 5), 16'd2);
        prep(0, 16'h0020);          // clear on A
        run_window(5'b00001);
        rd(ra(0, 3), v);    check("R5 clear on A count", v, 16'd2);
        rd(ra(0, 2), v);    check("R6 A and B flags", v, 16'h0006);
        wr(ra(0, 5), 16'd6);
        prep(0, 16'h0040);          // clear on B
        run_window(5'b00001);
        rd(ra(0, 3), v);    check("R5 clear on B count", v, 16'd4);
        rd(ra(0, 2), v);    check("R6 A flag without clear", v, 16'h0006);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        wr(ra(0, 4), 16'h0100);
        wr(ra(0, 5), 16'h0100);
        wr(ra(0, 1), 16'h0000);
        prep(0, 16'h0000);
        wr(ra(0, 3), 16'hFFF0);
        run_window(5'b00001);
        rd(ra(0, 3), v);    check("R3 wrapped count", v, 16'h0010);
        rd(ra(0, 2), v);    check("R3 overflow flag", v, 16'h0001);
        check("R4 irq masked", {15'd0, irq[0]}, 16'd0);
        wr(ra(0, 1), 16'h0001);
        check("R4 irq enabled", {15'd0, irq[0]}, 16'd1);
        repeat (5) @(negedge clk);
        check("R4 irq level holds", {15'd0, irq[0]}, 16'd1);
        wr(ra(0, 2), 16'h0006);
        check("R7 clear drops irq", {15'd0, irq[0]}, 16'd0);
        rd(ra(0, 2), v);    check("R7 flag cleared", v, 16'h0000);
        wr(ra(0, 1), 16'h0000);
    endtask

    task automatic t_collision;
        logic [15:0] v;
        wr(ra(0, 4), 16'd2);
        prep(0, 16'h0000);
        wr(6'd0, 16'h0001);         // start, ticks from the next edge
        @(negedge clk);
        wr(ra(0, 2), 16'h0000);     // lands on the edge where count==2 matches
        wr(6'd0, 16'h0000);
        rd(ra(0, 2), v);    check("R7 event beats clear", v & 16'h0002, 16'h0002);
    endtask

    task automatic t_external(input logic [1:0] edge_code, input int pin, input int exp);
        logic [15:0] v;
        prep(3, 16'({edge_code, 3'(4 + pin)}));
        wr(6'd0, 16'h0008);
        repeat (5) begin
            ext_clk[pin] = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk[pin] = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(6'd0, 16'h0000);
        rd(ra(3, 3), v);
        check($sformatf("R9 edge mode %0d pin %0d", edge_code, pin), v, 16'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_run_gate();
        t_divide();
        t_periodic();
        t_overflow();
        t_collision();
        t_external(2'b00, 0, 5);
        t_external(2'b01, 2, 5);
        t_external(2'b10, 3, 10);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule